// File: doc/BRIEF.md
# Programmable Skew Clock Output Banks

This block generates eight clock lines, arranged as four pairs, from one fast clock. A free-running phase counter steps once per fast cycle, and one nominal output period lasts 32 fast cycles. Each pair produces a square wave taken from that counter. The wave can be delayed or advanced by a signed number of time units, divided by two or four, or inverted, depending on which pair it is.

Every pair has its own control code made of two three-valued digits. A frequency-select digit sets how many fast cycles make up one time unit. Three more inputs control the outputs:
- a synchronous stop input halts the outputs, with the second pair exempt so it can keep serving as a feedback clock;
- an edge-polarity input chooses which reference edge the outputs line up with;
- a test digit, held at MID, lets individual pairs be disabled on their own.

Each digit is a 2-bit symbol: 2'b00 is LOW, 2'b01 is MID, 2'b10 is HIGH, and 2'b11 is read as MID. In `sel_i`, pair n (n = 0..3) uses bits [4n+3:4n]. Its first digit is in [4n+3:4n+2] and its second digit is in [4n+1:4n]. The code index is 3*first + second, with LOW=0, MID=1, HIGH=2. So LL=0, MM=4 and HH=8.

Top module: `skew_clock_banks`

## Requirements
- R1: While `rst_ni` is low, all eight outputs are 0 and the phase counter is at zero.
- R2: With every code at MM and `pe_i` high, each output is a 32-cycle square wave. It is high in the cycle after the counter reads 0..15 and low in the cycle after it reads 16..31. Both lines of a pair are always equal.
- R3: One time unit is 1 fast cycle when `fs_i` is LOW, 2 when it is MID and 4 when it is HIGH. A skew of k units delays the output by k*unit cycles modulo 32, and a negative k advances it.
- R4: Pairs 0 and 1 map code indices 0..8 to skews of -4, -3, -2, -1, 0, +1, +2, +3 and +4 units.
- R5: Pair 2 maps index 0 to divide-by-2 and index 8 to divide-by-4. Indices 1..7 give skews of -6, -4, -2, 0, +2, +4 and +6 units. Divide-by-2 is high for counter values 0..31 of a 64-count cycle, and divide-by-4 is high for 0..63 of a 128-count cycle.
- R6: Pair 3 maps index 0 to divide-by-2 and index 8 to the unskewed wave inverted. Indices 1..7 give the same even skews as pair 2.
- R7: With `pe_i` low, every output is the complement of its `pe_i`-high waveform.
- R8: While `soe_i` is high, every pair except pair 1 is stopped. A stopped output sits at 0 when `pe_i` is high and at 1 when `pe_i` is low.
- R9: A pair-3 output in inverted mode stops at 1 when `pe_i` is high and at 0 when `pe_i` is low.
- R10: An output starts or stops only in a cycle where its running waveform already equals its stopped level, so no shortened pulse appears.
- R11: When `test_i` is MID and `soe_i` is high, any pair whose code is LL is also stopped, including pair 1. Pairs with other codes behave as stated in R8.
- R12: The digit value 2'b11 behaves exactly like MID, both in codes and in `fs_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, 32 cycles per nominal output period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 2 | Time-unit select digit |
| pe_i | input | 1 | Edge polarity: 1 aligns to the rising reference edge, 0 to the falling edge |
| soe_i | input | 1 | Synchronous stop for all pairs except pair 1 |
| test_i | input | 2 | Test digit; MID enables stopping of individual pairs that have code LL |
| sel_i | input | 16 | Four per-pair codes, each made of two digits |
| q_o | output | 8 | Clock outputs; pair n drives bits 2n and 2n+1 |

## Verification
The bench steps a behavioural model of the counter, decode and gating every cycle and compares all eight lines on every clock. The same code is first applied to every pair, for all nine indices under each time-unit setting. This separates the fine-step table from the coarse one, shows the divide and invert codes, and shows how the unit length scales the delay. Mixed per-pair codes with `pe_i` low then check that polarity works independently of skew. Stop phases are applied with the stop input toggled mid-period and with LL codes under the test digit. These show which pairs are exempt, the stopped levels, and that the gate only switches at the idle level.

// File: rtl/skew_bank_pkg.sv
package skew_bank_pkg;
  typedef enum logic [1:0] {MODE_SKEW, MODE_DIV2, MODE_DIV4, MODE_INV} out_mode_e;
  typedef enum logic [1:0] {KIND_FINE, KIND_WIDE_DIV4, KIND_WIDE_INV} pair_kind_e;

  localparam logic [1:0] TRI_LO  = 2'b00;
  localparam logic [1:0] TRI_MID = 2'b01;
  localparam logic [1:0] TRI_HI  = 2'b10;

  function automatic logic [1:0] tri_norm(logic [1:0] d);
    return (d == 2'b11) ? TRI_MID : d;
  endfunction

  function automatic logic [3:0] tri_index(logic [1:0] hi, logic [1:0] lo);
    return {2'b00, tri_norm(hi)} * 4'd3 + {2'b00, tri_norm(lo)};
  endfunction
endpackage

// File: rtl/skew_phase_ctr.sv
module skew_phase_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
endmodule

// File: rtl/skew_pair_decode.sv
module skew_pair_decode
  import skew_bank_pkg::*;
#(
  parameter pair_kind_e KIND  = KIND_FINE,
  parameter int         OFF_W = 6
) (
  input  logic [3:0]              code_i,
  input  logic [1:0]              fs_i,
  output out_mode_e               mode_o,
  output logic signed [OFF_W-1:0] offset_o
);
  logic [3:0]              idx;
  logic signed [OFF_W-1:0] units;

  always_comb begin
    idx    = tri_index(code_i[3:2], code_i[1:0]);
    mode_o = MODE_SKEW;
    units  = '0;
    if (KIND == KIND_FINE) begin
      units = OFF_W'(int'(idx) - 4);
    end else if (idx == 4'd0) begin
      mode_o = MODE_DIV2;
    end else if (idx == 4'd8) begin
      mode_o = (KIND == KIND_WIDE_DIV4) ? MODE_DIV4 : MODE_INV;
    end else begin
      units = OFF_W'((int'(idx) - 4) * 2);
    end
    case (tri_norm(fs_i))
      TRI_LO:  offset_o = units;
      TRI_HI:  offset_o = units <<< 2;
      default: offset_o = units <<< 1;
    endcase
  end
endmodule

// File: rtl/skew_pair_gate.sv
module skew_pair_gate
  import skew_bank_pkg::*;
#(
  parameter int PHASE_W = 5,
  parameter int CNT_W   = PHASE_W + 2,
  parameter int OFF_W   = PHASE_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        cnt_i,
  input  out_mode_e               mode_i,
  input  logic signed [OFF_W-1:0] offset_i,
  input  logic                    pe_i,
  input  logic                    stop_i,
  output logic                    q_o
);
  logic [PHASE_W-1:0] phase;
  logic wave_hi, raw, idle, en_q, en_d;

  // negative offsets wrap modulo the period
  assign phase = cnt_i[PHASE_W-1:0] - offset_i[PHASE_W-1:0];

  always_comb begin
    case (mode_i)
      MODE_DIV2: wave_hi = ~cnt_i[PHASE_W];
      MODE_DIV4: wave_hi = ~cnt_i[PHASE_W+1];
      MODE_INV:  wave_hi = phase[PHASE_W-1];
      default:   wave_hi = ~phase[PHASE_W-1];
    endcase
    raw  = pe_i ? wave_hi : ~wave_hi;
    idle = (mode_i == MODE_INV) ? pe_i : ~pe_i;
    en_d = (raw == idle) ? ~stop_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
      q_o  <= 1'b0;
    end else begin
      en_q <= en_d;
      q_o  <= en_d ? raw : idle;
    end
  end

  a_r10_gate_at_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != $past(en_q)) |-> (q_o == $past(idle)));
  a_r8_run_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && raw == idle) |=> en_q);
  a_r9_stopped_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && $past(rst_ni)) |-> (q_o == $past(idle)));
endmodule

// File: rtl/skew_clock_banks.sv
module skew_clock_banks
  import skew_bank_pkg::*;
#(
  parameter int PHASE_W     = 5,
  parameter int N_PAIRS     = 4,
  parameter int EXEMPT_PAIR = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             fs_i,
  input  logic                   pe_i,
  input  logic                   soe_i,
  input  logic [1:0]             test_i,
  input  logic [4*N_PAIRS-1:0]   sel_i,
  output logic [2*N_PAIRS-1:0]   q_o
);
  localparam int CNT_W = PHASE_W + 2;
  localparam int OFF_W = PHASE_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             test_mid;

  assign test_mid = (tri_norm(test_i) == TRI_MID);

  skew_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cnt)
  );

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    localparam pair_kind_e KIND = (g < 2) ? KIND_FINE :
                                  (g == 2) ? KIND_WIDE_DIV4 : KIND_WIDE_INV;
    out_mode_e               mode;
    logic signed [OFF_W-1:0] offset;
    logic                    code_ll, stop, pair_q;

    assign code_ll = (tri_index(sel_i[4*g+3 -: 2], sel_i[4*g+1 -: 2]) == 4'd0);
    assign stop    = soe_i && ((g != EXEMPT_PAIR) || (test_mid && code_ll));

    skew_pair_decode #(.KIND(KIND), .OFF_W(OFF_W)) u_dec (
      .code_i(sel_i[4*g +: 4]), .fs_i(fs_i), .mode_o(mode), .offset_o(offset)
    );

    skew_pair_gate #(.PHASE_W(PHASE_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .mode_i(mode),
      .offset_i(offset), .pe_i(pe_i), .stop_i(stop), .q_o(pair_q)
    );

    assign q_o[2*g +: 2] = {2{pair_q}};
  end
endmodule

// File: tb/tb_skew_clock_banks.sv
module tb_skew_clock_banks;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  fs_i, test_i;
  logic        pe_i, soe_i;
  logic [15:0] sel_i;
  logic [7:0]  q_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_cnt = 0;
  bit m_en [8];

  always #5 clk = ~clk;

  skew_clock_banks dut (
    .clk_i(clk), .rst_ni(rst_ni), .fs_i(fs_i), .pe_i(pe_i), .soe_i(soe_i),
    .test_i(test_i), .sel_i(sel_i), .q_o(q_o)
  );

  function automatic int tnorm(int d);
    return (d == 3) ? 1 : d;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic run(int n, string tag);
    for (int c = 0; c < n; c++) begin
      logic [7:0] exp_q;
      @(negedge clk);
      for (int o = 0; o < 8; o++) begin
        int pair, code, idx, mode, units, tu, ph;
        bit hi, raw, idle, stop;
        pair  = o / 2;
        code  = (sel_i >> (4 * pair)) & 15;
        idx   = 3 * tnorm(code >> 2) + tnorm(code & 3);
        mode  = 0;  // 0 skew, 1 div2, 2 div4, 3 invert
        units = 0;
        if (pair < 2) units = idx - 4;
        else if (idx == 0) mode = 1;
        else if (idx == 8) mode = (pair == 2) ? 2 : 3;
        else units = (idx - 4) * 2;
        tu = (tnorm(fs_i) == 0) ? 1 : (tnorm(fs_i) == 2) ? 4 : 2;
        ph = ((m_cnt % 32) - units * tu + 64) % 32;
        case (mode)
          1: hi = (m_cnt % 64) < 32;
          2: hi = m_cnt < 64;
          3: hi = (m_cnt % 32) >= 16;
          default: hi = ph < 16;
        endcase
        raw  = pe_i ? hi : !hi;
        idle = (mode == 3) ? pe_i : !pe_i;
        stop = soe_i && (pair != 1 || (tnorm(test_i) == 1 && idx == 0));
        if (raw == idle) m_en[o] = !stop;
        exp_q[o] = m_en[o] ? raw : idle;
      end
      m_cnt = (m_cnt + 1) % 128;
      @(posedge clk); #2;
      checks++;
      if (q_o !== exp_q) begin
        fails++;
        $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, q_o, exp_q);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; fs_i = 2'b01; test_i = 2'b00; pe_i = 1'b1; soe_i = 1'b0;
    sel_i = 16'h5555;
    for (int i = 0; i < 8; i++) m_en[i] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (q_o !== 8'h00) begin
        fails++;
        $display("FAIL R1 reset actual=%b expected=%b", q_o, 8'h00);
      end
    end
    @(posedge clk); #2 rst_ni = 1'b1;

    run(70, "R2 all-MID");
    sel_i = 16'hFFFF; fs_i = 2'b11;
    run(40, "R12 code 11 as MID");

    for (int f = 0; f < 3; f++) begin
      for (int idx = 0; idx < 9; idx++) begin
        logic [3:0] nib;
        nib = {2'(idx / 3), 2'(idx % 3)};
        fs_i = 2'(f);
        sel_i = {4{nib}};
        run(132, "R3 R4 R5 R6 table sweep");
      end
    end

    fs_i = 2'b10; sel_i = 16'h2A19;
    run(130, "R4 R5 R6 mixed codes");
    pe_i = 1'b0; sel_i = 16'hA06B; fs_i = 2'b00;
    run(130, "R7 falling-edge polarity");
    sel_i = 16'h1593;
    run(70, "R7 mixed codes");

    pe_i = 1'b1; sel_i = 16'hA958; fs_i = 2'b01;
    soe_i = 1'b1;
    run(100, "R8 R9 stop pe high");
    pe_i = 1'b0;
    run(100, "R8 R9 stop pe low");
    soe_i = 1'b0;
    run(37, "R10 restart");
    for (int k = 0; k < 6; k++) begin
      soe_i = ~soe_i; pe_i = k[0];
      run(11 + 7 * k, "R10 toggled stop");
    end
    soe_i = 1'b0;
    run(70, "R10 settle");

    pe_i = 1'b1; test_i = 2'b01; sel_i = 16'h5005; soe_i = 1'b1;
    run(100, "R11 bank disable under test MID");
    sel_i = 16'h5095;
    run(70, "R11 exempt pair runs when not LL");
    soe_i = 1'b0; sel_i = 16'h0000;
    run(140, "R11 LL not disabled without stop");

    done = 1;
    summary();
    $finish;
  end
endmodule